// File: doc/BRIEF.md
# Packed Half-Word Operand Router

This block prepares operands for packed arithmetic in which one 32-bit word carries two independent 16-bit lanes. It takes three 32-bit sources. For each source and for each result lane it chooses the upper or lower half-word, and it can negate that half. The chosen halves feed two 16-bit three-input integer adders, one per result lane. The adders are part of the block so that the routing can be observed at the ports. An output scaling stage then acts on each lane sum, and the two lanes are packed into one 32-bit result.

In repack mode, used ahead of a dot-product engine, nothing is added. Sources 0 and 1 are rebuilt as full words from their chosen halves, and source 2 and the clamp flag are forwarded unchanged. A one-entry output slot holds every result behind a valid/ready handshake.

The slot is a two-state machine. **ST_EMPTY** moves to **ST_FULL** when an input is accepted. **ST_FULL** stays in ST_FULL while the consumer stalls, or when a drained entry is replaced by a new input in the same cycle. It returns to ST_EMPTY when the entry drains and no new input arrives.

Top module: `pk16_router`

## Requirements
- R1: For the low result lane, bit i of `lo_sel` picks bits 31:16 of source i when it is 1 and bits 15:0 when it is 0.
- R2: For the high result lane, bit i of `hi_sel` makes the same choice for source i, independently of `lo_sel`.
- R3: With `fp16_neg` at 0, bit i of `lo_neg` or `hi_neg` replaces the chosen half of source i by its two's complement (modulo 2^16) before use.
- R4: With `fp16_neg` at 1, a negate bit instead inverts only bit 15 of the chosen half.
- R5: Outside repack mode, each lane value is the sum modulo 2^16 of its three chosen halves. `result` is the high lane shifted left by 16, ORed with the low lane.
- R6: `omod` scales each lane sum: 0 leaves it unchanged, 1 shifts it left by one, 2 shifts it left by two (both dropping bits above bit 15), and 3 shifts it right by one arithmetically (bit 15 is kept).
- R7: In repack mode (`dot_mode` = 1), `dot_a` holds source 0's high-lane half in bits 31:16 and its low-lane half in bits 15:0, after negation. `dot_b` is built the same way from source 1. `result` is 0.
- R8: In repack mode, `dot_c` equals source 2 and `dot_clamp` equals `clamp_in`. Outside repack mode, `dot_a`, `dot_b`, `dot_c` and `dot_clamp` are 0.
- R9: `in_ready` is 1 when the slot is empty or `out_ready` is 1. An accepted input appears on the outputs with `out_valid` one cycle later. It stays stable while `out_valid` is 1 and `out_ready` is 0.
- R10: During reset, `out_valid` is 0 and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operands present |
| in_ready | output | 1 | Slot can take an input this cycle |
| src0 | input | 32 | Source 0 |
| src1 | input | 32 | Source 1 |
| src2 | input | 32 | Source 2 |
| lo_sel | input | 3 | Per-source half select for the low lane |
| hi_sel | input | 3 | Per-source half select for the high lane |
| lo_neg | input | 3 | Per-source negate for the low lane |
| hi_neg | input | 3 | Per-source negate for the high lane |
| fp16_neg | input | 1 | Negate flips the sign bit instead of two's complement |
| omod | input | 2 | Output scaling code |
| dot_mode | input | 1 | Repack mode |
| clamp_in | input | 1 | Clamp flag forwarded in repack mode |
| out_valid | output | 1 | Slot holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Packed two-lane result |
| dot_a | output | 32 | Repacked source 0 |
| dot_b | output | 32 | Repacked source 1 |
| dot_c | output | 32 | Forwarded source 2 |
| dot_clamp | output | 1 | Forwarded clamp flag |

## Verification
The arithmetic path is swept over every combination of low select, high select and negate mask. The scaling code and the negation style vary with the sweep. The three sources have distinct halves with mixed sign bits, so a swapped select bit, a wrong lane or a lost negation each gives a different sum.

Repack mode is swept over all select pairs with varied negate masks. This shows whether the upper and lower halves land in the right places of each rebuilt word. Directed values check the wrap-around of the left shifts and the sign kept by the right shift. A stall sequence shows that a waiting result is held, and that a second input is blocked until the consumer takes the first.

// File: rtl/pk16_pkg.sv
package pk16_pkg;
    typedef enum logic [1:0] {
        OM_NONE = 2'd0,
        OM_X2   = 2'd1,
        OM_X4   = 2'd2,
        OM_HALF = 2'd3
    } omod_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/pk16_half_pick.sv
module pk16_half_pick #(
    parameter int HW = 16
) (
    input  logic [2*HW-1:0] src,
    input  logic            upper,
    input  logic            negate,
    input  logic            sign_flip,
    output logic [HW-1:0]   half
);
    logic [HW-1:0] raw;

    always_comb begin
        raw = upper ? src[2*HW-1:HW] : src[HW-1:0];
        if (!negate)
            half = raw;
        else if (sign_flip)
            half = {~raw[HW-1], raw[HW-2:0]};
        else
            half = (~raw) + HW'(1);
    end
endmodule

// File: rtl/pk16_lane_alu.sv
module pk16_lane_alu
    import pk16_pkg::*;
#(
    parameter int HW   = 16,
    parameter int NSRC = 3
) (
    input  logic [NSRC*HW-1:0] ops,
    input  omod_e              scale,
    output logic [HW-1:0]      y
);
    logic [HW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int k = 0; k < NSRC; k++)
            sum = sum + ops[k*HW +: HW];
    end

    always_comb begin
        unique case (scale)
            OM_NONE: y = sum;
            OM_X2:   y = {sum[HW-2:0], 1'b0};
            OM_X4:   y = {sum[HW-3:0], 2'b00};
            OM_HALF: y = {sum[HW-1], sum[HW-1:1]};
            default: y = sum;
        endcase
    end
endmodule

// File: rtl/pk16_out_slot.sv
module pk16_out_slot
    import pk16_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] d,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] q
);
    slot_e st, st_nx;
    logic  take;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_EMPTY;
        else
            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_EMPTY: if (in_valid) st_nx = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) st_nx = ST_EMPTY;
            default:  st_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (st)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
            default:  begin out_valid = 1'b0; in_ready = 1'b0;      end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (take)
            q <= d;
    end
endmodule

// File: rtl/pk16_router.sv
module pk16_router
    import pk16_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [2*HW-1:0] src0,
    input  logic [2*HW-1:0] src1,
    input  logic [2*HW-1:0] src2,
    input  logic [2:0]      lo_sel,
    input  logic [2:0]      hi_sel,
    input  logic [2:0]      lo_neg,
    input  logic [2:0]      hi_neg,
    input  logic            fp16_neg,
    input  logic [1:0]      omod,
    input  logic            dot_mode,
    input  logic            clamp_in,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [2*HW-1:0] result,
    output logic [2*HW-1:0] dot_a,
    output logic [2*HW-1:0] dot_b,
    output logic [2*HW-1:0] dot_c,
    output logic            dot_clamp
);
    localparam int NSRC = 3;
    localparam int DW   = 2 * HW;
    localparam int PW   = 4 * DW + 1;

    logic [NSRC-1:0][DW-1:0] srcs;
    logic [NSRC*HW-1:0]      lo_ops, hi_ops;
    logic [HW-1:0]           lo_y, hi_y;
    logic [PW-1:0]           nxt, held;

    assign srcs = {src2, src1, src0};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        pk16_half_pick #(.HW(HW)) u_lo (
            .src(srcs[s]), .upper(lo_sel[s]), .negate(lo_neg[s]),
            .sign_flip(fp16_neg), .half(lo_ops[s*HW +: HW])
        );
        pk16_half_pick #(.HW(HW)) u_hi (
            .src(srcs[s]), .upper(hi_sel[s]), .negate(hi_neg[s]),
            .sign_flip(fp16_neg), .half(hi_ops[s*HW +: HW])
        );
    end

    pk16_lane_alu #(.HW(HW), .NSRC(NSRC)) u_lo_alu (
        .ops(lo_ops), .scale(omod_e'(omod)), .y(lo_y)
    );
    pk16_lane_alu #(.HW(HW), .NSRC(NSRC)) u_hi_alu (
        .ops(hi_ops), .scale(omod_e'(omod)), .y(hi_y)
    );

    always_comb begin
        if (dot_mode)
            nxt = {DW'(0),
                   hi_ops[0 +: HW], lo_ops[0 +: HW],
                   hi_ops[HW +: HW], lo_ops[HW +: HW],
                   src2, clamp_in};
        else
            nxt = {hi_y, lo_y, DW'(0), DW'(0), DW'(0), 1'b0};
    end

    pk16_out_slot #(.PW(PW)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .d(nxt),
        .out_valid(out_valid), .out_ready(out_ready), .q(held)
    );

    assign {result, dot_a, dot_b, dot_c, dot_clamp} = held;
endmodule

// File: rtl/pk16_router_chk.sv
module pk16_router_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          dot_mode,
    input logic [DW-1:0] src2,
    input logic          clamp_in,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] result,
    input logic [DW-1:0] dot_a,
    input logic [DW-1:0] dot_c,
    input logic          dot_clamp
);
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R9
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result) && $stable(dot_a)); // R9
    AST_CAPTURE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9
    AST_REPACK_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && dot_mode |=> result == '0); // R7
    AST_REPACK_PASS_C: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && dot_mode |=> dot_c == $past(src2) && dot_clamp == $past(clamp_in)); // R8
    AST_PLAIN_DOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !dot_mode |=> dot_a == '0 && dot_c == '0 && !dot_clamp); // R8
endmodule

bind pk16_router pk16_router_chk #(.DW(2*HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dot_mode(dot_mode), .src2(src2), .clamp_in(clamp_in),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .dot_a(dot_a), .dot_c(dot_c), .dot_clamp(dot_clamp)
);

// File: tb/pk16_router_test.sv
module pk16_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] src0 = '0, src1 = '0, src2 = '0;
    logic [2:0]  lo_sel = '0, hi_sel = '0, lo_neg = '0, hi_neg = '0;
    logic        fp16_neg = 1'b0, dot_mode = 1'b0, clamp_in = 1'b0;
    logic [1:0]  omod = '0;
    logic        out_valid, out_ready = 1'b1;
    logic [31:0] result, dot_a, dot_b, dot_c;
    logic        dot_clamp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pk16_router uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src0(src0), .src1(src1), .src2(src2),
        .lo_sel(lo_sel), .hi_sel(hi_sel), .lo_neg(lo_neg), .hi_neg(hi_neg),
        .fp16_neg(fp16_neg), .omod(omod), .dot_mode(dot_mode), .clamp_in(clamp_in),
        .out_valid(out_valid), .out_ready(out_ready), .result(result),
        .dot_a(dot_a), .dot_b(dot_b), .dot_c(dot_c), .dot_clamp(dot_clamp)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input logic [31:0] s, input bit up, input bit ng, input bit fp);
        logic [15:0] h;
        h = up ? s[31:16] : s[15:0];
        if (ng) h = fp ? (h ^ 16'h8000) : 16'(-h);
        return h;
    endfunction

    function automatic logic [15:0] scale(input logic [15:0] v, input logic [1:0] c);
        case (c)
            2'd0: return v;
            2'd1: return 16'(v << 1);
            2'd2: return 16'(v << 2);
            default: return 16'($signed(v) >>> 1);
        endcase
    endfunction

    function automatic logic [15:0] lane(input logic [2:0] sl, input logic [2:0] ng,
                                         input bit fp, input logic [1:0] c);
        return scale(16'(pick(src0, sl[0], ng[0], fp) + pick(src1, sl[1], ng[1], fp)
                         + pick(src2, sl[2], ng[2], fp)), c);
    endfunction

    task automatic send;
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        src0 = 32'h1234_8765; src1 = 32'hFEDC_0011; src2 = 32'h0F0F_7FFF;
        repeat (2) @(negedge clk);
        chk("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R10 result in reset", result, 32'd0);
        chk("R10 dot_a in reset", dot_a, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 ready when empty", {31'd0, in_ready}, 32'd1);

        // arithmetic sweep: R1 R2 R3 R4 R5 R6
        for (int sl = 0; sl < 8; sl++)
            for (int sh = 0; sh < 8; sh++)
                for (int ng = 0; ng < 8; ng++) begin
                    lo_sel = 3'(sl); hi_sel = 3'(sh);
                    lo_neg = 3'(ng); hi_neg = 3'(7 - ng);
                    fp16_neg = ng[0] ^ sl[0];
                    omod = 2'(sl + sh);
                    dot_mode = 1'b0;
                    send();
                    chk("R1 R2 R3 R4 R5 R6 packed result", result,
                        {lane(hi_sel, hi_neg, fp16_neg, omod), lane(lo_sel, lo_neg, fp16_neg, omod)});
                    chk("R9 valid after accept", {31'd0, out_valid}, 32'd1);
                end
        chk("R8 dot_a zero outside repack", dot_a, 32'd0);
        chk("R8 dot_b zero outside repack", dot_b, 32'd0);
        chk("R8 dot_c zero outside repack", dot_c, 32'd0);

        // repack sweep: R7 R8
        for (int sl = 0; sl < 8; sl++)
            for (int sh = 0; sh < 8; sh++) begin
                lo_sel = 3'(sl); hi_sel = 3'(sh);
                lo_neg = 3'(sl ^ sh); hi_neg = 3'(sh + 1);
                fp16_neg = sl[1]; clamp_in = sh[0]; dot_mode = 1'b1; omod = 2'd1;
                send();
                chk("R7 dot_a repack", dot_a,
                    {pick(src0, sh[0], hi_neg[0], fp16_neg), pick(src0, sl[0], lo_neg[0], fp16_neg)});
                chk("R7 dot_b repack", dot_b,
                    {pick(src1, sh[1], hi_neg[1], fp16_neg), pick(src1, sl[1], lo_neg[1], fp16_neg)});
                chk("R7 result zero in repack", result, 32'd0);
                chk("R8 dot_c passthrough", dot_c, src2);
                chk("R8 clamp passthrough", {31'd0, dot_clamp}, {31'd0, clamp_in});
            end

        // scaling corners: R6
        dot_mode = 1'b0; src0 = 32'h8001_4000; src1 = '0; src2 = '0;
        lo_sel = 3'b000; hi_sel = 3'b001; lo_neg = '0; hi_neg = '0; fp16_neg = 1'b0;
        omod = 2'd1; send(); chk("R6 x2 wraps", result, 32'h0002_8000);
        omod = 2'd2; send(); chk("R6 x4 wraps", result, 32'h0004_0000);
        omod = 2'd3; send(); chk("R6 half keeps sign", result, 32'hC000_2000);
        omod = 2'd0; send(); chk("R6 no change", result, 32'h8001_4000);

        // negate style corner: R3 R4
        lo_neg = 3'b001; hi_neg = 3'b001;
        fp16_neg = 1'b0; send(); chk("R3 two's complement", result, 32'h7FFF_C000);
        fp16_neg = 1'b1; send(); chk("R4 sign flip", result, 32'h0001_C000);

        // stall: R9
        @(negedge clk);
        out_ready = 1'b0; fp16_neg = 1'b0; lo_neg = '0; hi_neg = '0;
        in_valid = 1'b1;
        @(negedge clk);
        src0 = 32'h0005_0003;
        chk("R9 not ready while stalled", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        chk("R9 held while stalled", result, 32'h8001_4000);
        chk("R9 valid while stalled", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        #1;
        chk("R9 ready when drained", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 second input taken", result, 32'h0005_0003);
        @(negedge clk);
        chk("R9 empty after drain", {31'd0, out_valid}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule